// File: doc/BRIEF.md
# Run-Length Ones-Then-Zeros Detector

This block watches a single serial bit stream, one bit taken on each rising clock edge, and raises a flag when it sees a run of at least two consecutive ones that is followed directly by a run of zeros. The flag goes up on the third zero of that zero run. It stays up for the rest of the run and drops when the next one arrives. A zero run that follows a lone one never qualifies, and neither does a zero run that a one cuts short before its third zero.

The flag is decoded from the stored run state together with the bit that is on the input now. It therefore answers for the current bit in the same cycle, with no added latency. The one that ends a held flag also starts a new ones run, so back-to-back qualifying patterns are each reported. A synchronous, active-high reset discards any partial run. There is no handshake: the stream is assumed to carry a valid bit in every clock cycle.

Top module: `rlz_detect`

## Requirements
- R1: `hit_out` depends on the bit present on `bit_in` in the current cycle combined with the history captured at earlier rising edges, so it responds to a bit in the cycle in which that bit is presented.
- R2: `hit_out` becomes 1 in the cycle in which the third consecutive 0 is presented, provided that 0 run directly follows a run of two or more consecutive 1s.
- R3: Once set, `hit_out` stays 1 for every further consecutive 0.
- R4: `hit_out` returns to 0 in the cycle in which a 1 is presented after the hold.
- R5: A 0 run that directly follows a single 1 (a 1 with a 0 or a reset on both sides) keeps `hit_out` at 0, however long the run is.
- R6: A run of two or more 1s followed by only one or two 0s and then a 1 keeps `hit_out` at 0 throughout.
- R7: A run of four 1s followed by five 0s sets `hit_out` on the third, fourth and fifth 0 and on no other bit.
- R8: The 1 that ends a hold counts as the first 1 of a new run, so a following 1 and three 0s set `hit_out` again on the third 0.
- R9: While `rst` is 1, `hit_out` is 0. The first rising edge with `rst` at 1 returns the detector to its empty state, and a partial ones or zeros run seen before the reset is forgotten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The input bit is taken on the rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| bit_in | input | 1 | Serial data bit, one per cycle. |
| hit_out | output | 1 | Detection flag for the bit currently on `bit_in`. |

## Verification
Two functions can fall in one cycle: a 1 that ends a held flag also opens the next ones run. The bench provokes this by following a hold directly with 1,1,0,0,0,0. In the cycle of the first 1 it expects the flag to drop, and it expects the flag to rise again on the third 0 of the new zero run. The same overlap is judged on every cycle of the 33-bit mixed example stream against a run-length counting model written independently of the state encoding.

// File: rtl/rlz_pkg.sv
package rlz_pkg;

  // Run tracker states; the encoding width follows the state count.
  localparam int unsigned NUM_STATES = 6;
  localparam int unsigned STATE_W    = $clog2(NUM_STATES);

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,  // nothing useful seen, or a broken run
    ST_ONE   = 3'd1,  // a single 1 is the latest run
    ST_ONES  = 3'd2,  // two or more 1s in a row
    ST_ZERO1 = 3'd3,  // one 0 after a qualifying ones run
    ST_ZERO2 = 3'd4,  // two 0s after a qualifying ones run
    ST_HOLD  = 3'd5   // three or more 0s after a qualifying ones run
  } rlz_state_e;

endpackage

// File: rtl/rlz_next.sv
module rlz_next
  import rlz_pkg::*;
(
  input  rlz_state_e cur_state,
  input  logic       bit_in,
  output rlz_state_e nxt_state
);

  always_comb begin
    nxt_state = ST_IDLE;
    unique case (cur_state)
      ST_IDLE:  nxt_state = bit_in ? ST_ONE  : ST_IDLE;
      ST_ONE:   nxt_state = bit_in ? ST_ONES : ST_IDLE;
      ST_ONES:  nxt_state = bit_in ? ST_ONES : ST_ZERO1;
      ST_ZERO1: nxt_state = bit_in ? ST_ONE  : ST_ZERO2;
      ST_ZERO2: nxt_state = bit_in ? ST_ONE  : ST_HOLD;
      ST_HOLD:  nxt_state = bit_in ? ST_ONE  : ST_HOLD;
      default:  nxt_state = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rlz_state_reg.sv
module rlz_state_reg
  import rlz_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rlz_state_e nxt_state,
  output rlz_state_e cur_state
);

  always_ff @(posedge clk) begin
    if (rst) cur_state <= ST_IDLE;
    else     cur_state <= nxt_state;
  end

endmodule

// File: rtl/rlz_out.sv
module rlz_out
  import rlz_pkg::*;
(
  input  logic       rst,
  input  rlz_state_e cur_state,
  input  logic       bit_in,
  output logic       hit_out
);

  logic armed;

  // A 0 completes or extends the qualifying zero run only from these states.
  always_comb begin
    unique case (cur_state)
      ST_ZERO2, ST_HOLD: armed = 1'b1;
      default:           armed = 1'b0;
    endcase
  end

  assign hit_out = armed & ~bit_in & ~rst;

endmodule

// File: rtl/rlz_detect.sv
module rlz_detect
  import rlz_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit_out
);

  rlz_state_e cur_state;
  rlz_state_e nxt_state;

  rlz_next u_next (
    .cur_state (cur_state),
    .bit_in    (bit_in),
    .nxt_state (nxt_state)
  );

  rlz_state_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (nxt_state),
    .cur_state (cur_state)
  );

  rlz_out u_out (
    .rst       (rst),
    .cur_state (cur_state),
    .bit_in    (bit_in),
    .hit_out   (hit_out)
  );

endmodule

// File: rtl/rlz_detect_chk.sv
module rlz_detect_chk
  import rlz_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bit_in,
  input logic       hit_out,
  input rlz_state_e cur_state
);

  // R9: the flag is low for as long as reset is held
  always @(negedge clk) begin
    if (rst) begin
      p_reset_quiet_r9: assert (!hit_out)
        else $error("flag high during reset");
    end
  end

  // R2: a rising flag has two 1s and then three 0s behind it
  p_rise_pattern_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_out) |-> (!bit_in && !$past(bit_in) && !$past(bit_in, 2)
                        && $past(bit_in, 3) && $past(bit_in, 4)));

  // R3: a raised flag survives another 0
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    hit_out |=> (bit_in || hit_out));

  // R4: the flag only falls when a 1 is presented
  p_drop_on_one_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hit_out) |-> bit_in);

  // R5: a zero after a lone 1 never raises the flag on the next bit
  p_lone_one_r5: assert property (@(posedge clk) disable iff (rst)
    (cur_state == ST_ONE && !bit_in) |=> !hit_out);

endmodule

bind rlz_detect rlz_detect_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_in    (bit_in),
  .hit_out   (hit_out),
  .cur_state (cur_state)
);

// File: tb/tb_rlz_detect.sv
`timescale 1ns/1ps
module tb_rlz_detect;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit_out;

  always #2.5 clk = ~clk;

  rlz_detect dut (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .hit_out (hit_out)
  );

  bit    exp_q[$];
  string tag_q[$];
  int    compared   = 0;
  int    mismatched = 0;
  bit    done       = 1'b0;

  // independent run-length model
  int  m_ones  = 0;
  int  m_zeros = 0;
  bit  m_qual  = 1'b0;

  task automatic model_clear();
    m_ones = 0; m_zeros = 0; m_qual = 1'b0;
  endtask

  function automatic bit model_step(bit b);
    bit e;
    if (b) begin
      m_ones  = m_ones + 1;
      m_zeros = 0;
      m_qual  = 1'b0;
      e = 1'b0;
    end else begin
      if (m_zeros == 0) m_qual = (m_ones >= 2);
      m_zeros = m_zeros + 1;
      m_ones  = 0;
      e = m_qual && (m_zeros >= 3);
    end
    return e;
  endfunction

  // driver: present a bit and queue its expected flag
  task automatic drive_bit(bit b, string tag);
    @(negedge clk);
    rst    = 1'b0;
    bit_in = b;
    exp_q.push_back(model_step(b));
    tag_q.push_back(tag);
  endtask

  task automatic drive_reset(int cycles, bit b);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rst    = 1'b1;
      bit_in = b;
      model_clear();
      exp_q.push_back(1'b0);
      tag_q.push_back("R9 reset");
    end
  endtask

  task automatic drive_vec(string bits, string tag);
    for (int i = 0; i < bits.len(); i++)
      drive_bit(bits[i] == "1", tag);
  endtask

  // monitor: compare in the low phase, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() != 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (hit_out !== e) begin
          mismatched++;
          $display("FAIL %s: hit_out=%0b expected=%0b at %0t", t, hit_out, e, $time);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    drive_reset(3, 1'b1);
    // mixed example stream
    drive_vec("100011000011100100011110000011000", "R1 R2 R3 R4 R6 stream");
    // lone 1 then a long zero run
    drive_vec("1000000", "R5 lone one");
    // short zero runs broken by a 1
    drive_vec("1110010011010", "R6 short zeros");
    // four ones then five zeros
    drive_vec("111100000", "R7 long runs");
    // the 1 that ends the hold starts a new run
    drive_vec("110000", "R8 overlap");
    // reset inside a partial run wipes it
    drive_vec("1100", "R9 pre-reset");
    drive_reset(1, 1'b0);
    drive_vec("0000", "R9 after reset");
    drive_vec("11", "R9 ones");
    drive_reset(1, 1'b0);
    drive_vec("000", "R9 ones forgotten");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule